// File: doc/BRIEF.md
# Windowed Integer Register File

This block is an integer register file for a processor whose procedures each get a fresh set of registers without any copying. Software addresses 32 architectural registers. The block maps each one onto a physical array of 520 entries. Eight registers are global and every procedure sees the same ones. The rest come from a window that depends on a 5-bit window pointer. Each window shows 24 registers in three groups of eight: outgoing, local and incoming. Neighbouring windows share one group. A caller places arguments in its outgoing group. After the call moves the pointer down by one, the callee finds those same arguments in its incoming group.

A save strobe moves the pointer down by one and a restore strobe moves it up by one. Both wrap around modulo 32. A 32-bit invalid-window mask has one bit per window and marks windows that are occupied elsewhere. If a save or restore would enter a marked window, the pointer stays where it is and the block raises an overflow or underflow trap. Software can load the pointer and the mask directly. The block offers two combinational read ports and one write port. The write is committed on the clock edge, and a read of the register being written in the same cycle sees the new data.

Top module: `wrf_regfile`

## Requirements
- R1: After reset the window pointer is 0, the invalid-window mask is all zeros, and both trap outputs are low.
- R2: Architectural register 0 always reads as zero on both read ports. Writes to it are discarded.
- R3: Architectural registers 1 to 7 select the same physical registers whatever the window pointer is.
- R4: Architectural register n from 8 to 31 maps to physical entry 8 + ((P*16 + (n-8)) mod 512), where P is the window pointer in the cycle of the access. Reads are combinational. A write is visible from the next clock edge on. The locals (16 to 23) of different windows are therefore distinct.
- R5: The outgoing group (8 to 15) of window w is the same storage as the incoming group (24 to 31) of window w-1 mod 32.
- R6: A save strobe on its own moves the pointer to P-1 mod 32 at the next edge when mask bit P-1 is clear, so 0 becomes 31.
- R7: A restore strobe on its own moves the pointer to P+1 mod 32 at the next edge when mask bit P+1 is clear, so 31 becomes 0.
- R8: A save strobe whose target window has its mask bit set leaves the pointer unchanged. It also drives overflow_trap high for exactly the one cycle after that edge.
- R9: A restore strobe whose target window has its mask bit set leaves the pointer unchanged. It also drives underflow_trap high for exactly the one cycle after that edge.
- R10: While a write is enabled to a nonzero register, a read of the same architectural register in the same cycle returns the write data.
- R11: A pointer load or mask load takes effect at the next edge. A pointer load takes priority over a save or restore in the same cycle, and no trap is raised in that cycle.
- R12: A save and a restore strobe asserted together are ignored. The pointer stays the same and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Architectural index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 5 | Architectural index for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural index for the write |
| wr_data | input | 32 | Write data |
| save_i | input | 1 | Move the window pointer down by one |
| restore_i | input | 1 | Move the window pointer up by one |
| ptr_we | input | 1 | Load the window pointer |
| ptr_wdata | input | 5 | Window pointer load value |
| mask_we | input | 1 | Load the invalid-window mask |
| mask_wdata | input | 32 | Invalid-window mask load value |
| win_ptr | output | 5 | Current window pointer |
| inv_mask | output | 32 | Current invalid-window mask |
| overflow_trap | output | 1 | One-cycle pulse: a save was refused |
| underflow_trap | output | 1 | One-cycle pulse: a restore was refused |

## Verification
The hardest case to reach from the ports is a value that must cross a window boundary while the pointer wraps. The stimulus writes an outgoing register in window 0, saves into window 31, and reads that value back through an incoming register there. It then writes a local in window 31 and restores to window 0, where the original local must still be intact. Trap cases are built by loading the pointer and then placing the mask bit exactly on the target window. The bench checks that the pointer does not move and that the trap lasts one cycle only.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    localparam int ARCH_W      = 5;
    localparam int NGLOB       = 8;
    localparam int STRIDE      = 16;
    localparam int STRIDE_LOG2 = $clog2(STRIDE);
endpackage

// File: rtl/wrf_xlate.sv
module wrf_xlate
    import wrf_pkg::*;
#(
    parameter int PTR_W  = 5,
    parameter int PIDX_W = 10
) (
    input  logic [ARCH_W-1:0] arch_idx,
    input  logic [PTR_W-1:0]  ptr,
    output logic [PIDX_W-1:0] phys_idx
);
    localparam int SPAN_W = PTR_W + STRIDE_LOG2;

    logic [SPAN_W-1:0] base;
    logic [ARCH_W-1:0] off;
    logic [SPAN_W-1:0] sum;

    always_comb begin
        base = {ptr, {STRIDE_LOG2{1'b0}}};
        off  = arch_idx - ARCH_W'(NGLOB);
        // truncation to SPAN_W bits performs the modulo of the window span
        sum  = base + SPAN_W'(off);
        if (arch_idx < ARCH_W'(NGLOB))
            phys_idx = PIDX_W'(arch_idx);
        else
            phys_idx = PIDX_W'(NGLOB) + PIDX_W'(sum);
    end
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl #(
    parameter int NWIN  = 32,
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_i,
    input  logic             restore_i,
    input  logic             ptr_we,
    input  logic [PTR_W-1:0] ptr_wdata,
    input  logic             mask_we,
    input  logic [NWIN-1:0]  mask_wdata,
    output logic [PTR_W-1:0] ptr_q_o,
    output logic [NWIN-1:0]  mask_q_o,
    output logic             ovf_o,
    output logic             unf_o
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [NWIN-1:0]  mask;
        logic             ovf;
        logic             unf;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [PTR_W-1:0] down_ptr, up_ptr;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        down_ptr = st_q.ptr - PTR_W'(1);
        up_ptr   = st_q.ptr + PTR_W'(1);
        if (mask_we)
            st_d.mask = mask_wdata;
        if (ptr_we) begin
            st_d.ptr = ptr_wdata;
        end else if (save_i && !restore_i) begin
            if (st_q.mask[down_ptr]) st_d.ovf = 1'b1;
            else                     st_d.ptr = down_ptr;
        end else if (restore_i && !save_i) begin
            if (st_q.mask[up_ptr]) st_d.unf = 1'b1;
            else                   st_d.ptr = up_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_q_o  = st_q.ptr;
    assign mask_q_o = st_q.mask;
    assign ovf_o    = st_q.ovf;
    assign unf_o    = st_q.unf;
endmodule

// File: rtl/wrf_array.sv
module wrf_array #(
    parameter int DW     = 32,
    parameter int NPHYS  = 520,
    parameter int PIDX_W = 10,
    parameter int NRD    = 2
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [PIDX_W-1:0]           wr_phys,
    input  logic [DW-1:0]               wr_data,
    input  logic [NRD-1:0][PIDX_W-1:0]  rd_phys,
    output logic [NRD-1:0][DW-1:0]      rd_data
);
    logic [DW-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (wr_en && wr_phys != '0)
            mem[wr_phys] <= wr_data;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_phys[p] == '0)
                rd_data[p] = '0;
            else if (wr_en && wr_phys == rd_phys[p])
                rd_data[p] = wr_data;
            else
                rd_data[p] = mem[rd_phys[p]];
        end
    end
endmodule

// File: rtl/wrf_regfile.sv
module wrf_regfile
    import wrf_pkg::*;
#(
    parameter int NWIN = 32,
    parameter int DW   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [4:0]                    rd_a_idx,
    output logic [DW-1:0]                 rd_a_data,
    input  logic [4:0]                    rd_b_idx,
    output logic [DW-1:0]                 rd_b_data,
    input  logic                          wr_en,
    input  logic [4:0]                    wr_idx,
    input  logic [DW-1:0]                 wr_data,
    input  logic                          save_i,
    input  logic                          restore_i,
    input  logic                          ptr_we,
    input  logic [$clog2(NWIN)-1:0]       ptr_wdata,
    input  logic                          mask_we,
    input  logic [NWIN-1:0]               mask_wdata,
    output logic [$clog2(NWIN)-1:0]       win_ptr,
    output logic [NWIN-1:0]               inv_mask,
    output logic                          overflow_trap,
    output logic                          underflow_trap
);
    localparam int PTR_W  = $clog2(NWIN);
    localparam int NPHYS  = NGLOB + NWIN * STRIDE;
    localparam int PIDX_W = $clog2(NPHYS);
    localparam int NRD    = 2;
    localparam int NACC   = NRD + 1;

    logic [NACC-1:0][ARCH_W-1:0] arch_idx;
    logic [NACC-1:0][PIDX_W-1:0] phys_idx;
    logic [NRD-1:0][PIDX_W-1:0]  rd_phys;
    logic [NRD-1:0][DW-1:0]      rd_data;

    assign arch_idx[0] = rd_a_idx;
    assign arch_idx[1] = rd_b_idx;
    assign arch_idx[2] = wr_idx;

    wrf_ctrl #(.NWIN(NWIN), .PTR_W(PTR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .save_i     (save_i),
        .restore_i  (restore_i),
        .ptr_we     (ptr_we),
        .ptr_wdata  (ptr_wdata),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .ptr_q_o    (win_ptr),
        .mask_q_o   (inv_mask),
        .ovf_o      (overflow_trap),
        .unf_o      (underflow_trap)
    );

    for (genvar i = 0; i < NACC; i++) begin : g_xl
        wrf_xlate #(.PTR_W(PTR_W), .PIDX_W(PIDX_W)) u_xl (
            .arch_idx (arch_idx[i]),
            .ptr      (win_ptr),
            .phys_idx (phys_idx[i])
        );
    end

    assign rd_phys[0] = phys_idx[0];
    assign rd_phys[1] = phys_idx[1];

    wrf_array #(.DW(DW), .NPHYS(NPHYS), .PIDX_W(PIDX_W), .NRD(NRD)) u_arr (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_phys (phys_idx[2]),
        .wr_data (wr_data),
        .rd_phys (rd_phys),
        .rd_data (rd_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
endmodule

// File: rtl/wrf_regfile_chk.sv
module wrf_regfile_chk #(
    parameter int NWIN = 32,
    parameter int DW   = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [4:0]              rd_a_idx,
    input logic [DW-1:0]           rd_a_data,
    input logic [4:0]              rd_b_idx,
    input logic [DW-1:0]           rd_b_data,
    input logic                    wr_en,
    input logic [4:0]              wr_idx,
    input logic [DW-1:0]           wr_data,
    input logic                    save_i,
    input logic                    restore_i,
    input logic                    ptr_we,
    input logic [$clog2(NWIN)-1:0] ptr_wdata,
    input logic                    mask_we,
    input logic [NWIN-1:0]         mask_wdata,
    input logic [$clog2(NWIN)-1:0] win_ptr,
    input logic [NWIN-1:0]         inv_mask,
    input logic                    overflow_trap,
    input logic                    underflow_trap
);
    localparam int PTR_W = $clog2(NWIN);
    logic [PTR_W-1:0] dn, up;
    assign dn = win_ptr - PTR_W'(1);
    assign up = win_ptr + PTR_W'(1);

    // R2
    zero_reg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_idx == 5'd0 |-> rd_a_data == '0);

    // R6
    save_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_i && !restore_i && !ptr_we && !inv_mask[dn] |=> win_ptr == $past(dn));

    // R7
    restore_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i && !save_i && !ptr_we && !inv_mask[up] |=> win_ptr == $past(up));

    // R8
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_i && !restore_i && !ptr_we && inv_mask[dn] |=> overflow_trap && $stable(win_ptr));

    // R9
    underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i && !save_i && !ptr_we && inv_mask[up] |=> underflow_trap && $stable(win_ptr));

    // R10
    bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx != 5'd0 && wr_idx == rd_a_idx |-> rd_a_data == wr_data);

    // R12
    both_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_i && restore_i && !ptr_we |=> $stable(win_ptr) && !overflow_trap && !underflow_trap);

    // R11
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> win_ptr == $past(ptr_wdata) && !overflow_trap && !underflow_trap);
endmodule

bind wrf_regfile wrf_regfile_chk #(.NWIN(NWIN), .DW(DW)) u_chk (.*);

// File: tb/wrf_regfile_tb.sv
module wrf_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, save_i, restore_i, ptr_we, mask_we;
    logic [4:0]  ptr_wdata, win_ptr;
    logic [31:0] mask_wdata, inv_mask;
    logic        overflow_trap, underflow_trap;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wrf_regfile u_dut (.*);

    // {wr_idx, wr_data, rd_idx, expected}
    localparam logic [73:0] VEC [6] = '{
        {5'd1,  32'h1111_1111, 5'd1,  32'h1111_1111},  // R3 global
        {5'd0,  32'hDEAD_BEEF, 5'd0,  32'h0000_0000},  // R2 write discarded
        {5'd8,  32'hA0A0_0008, 5'd8,  32'hA0A0_0008},  // R4 out group
        {5'd16, 32'h1616_0000, 5'd16, 32'h1616_0000},  // R4 local group
        {5'd24, 32'h2424_0000, 5'd24, 32'h2424_0000},  // R4 in group
        {5'd31, 32'h3131_0000, 5'd31, 32'h3131_0000}   // R4 last in
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; save_i = 0; restore_i = 0; ptr_we = 0; mask_we = 0;
    endtask

    task automatic rd_chk(input logic [4:0] idx, input logic [31:0] exp, input string tag);
        rd_a_idx = idx;
        rd_b_idx = idx;
        #1;
        chk({tag, " portA"}, rd_a_data, exp);
        chk({tag, " portB"}, rd_b_data, exp);
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] d);
        wr_en = 1; wr_idx = idx; wr_data = d;
        step();
        wr_en = 0;
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0; rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
        ptr_wdata = 0; mask_wdata = 0;
        @(negedge clk); step(); step();
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 win_ptr", 32'(win_ptr), 32'd0);
        chk("R1 inv_mask", inv_mask, 32'd0);
        chk("R1 traps", {30'd0, overflow_trap, underflow_trap}, 32'd0);
        rd_chk(5'd0, 32'd0, "R2 r0 after reset");
        @(negedge clk);

        // table walk at window 0
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][73:69], VEC[i][68:37]);
            rd_chk(VEC[i][36:32], VEC[i][31:0], $sformatf("R4 vec%0d", i));
            @(negedge clk);
        end

        // R10 same-cycle bypass
        wr_en = 1; wr_idx = 5'd9; wr_data = 32'hCAFE_0009;
        rd_a_idx = 5'd9; rd_b_idx = 5'd9;
        #1;
        chk("R10 bypass A", rd_a_data, 32'hCAFE_0009);
        chk("R10 bypass B", rd_b_data, 32'hCAFE_0009);
        @(negedge clk); wr_en = 0;

        // R6 wrap 0 -> 31, R5 overlap, R3 global
        save_i = 1; step(); save_i = 0;
        chk("R6 save wrap", 32'(win_ptr), 32'd31);
        rd_chk(5'd24, 32'hA0A0_0008, "R5 out0 seen as in31");
        rd_chk(5'd1, 32'h1111_1111, "R3 global in w31");
        @(negedge clk);
        wr(5'd16, 32'h1616_0031);
        rd_chk(5'd16, 32'h1616_0031, "R4 local w31");
        @(negedge clk);

        // R7 wrap 31 -> 0, locals private
        restore_i = 1; step(); restore_i = 0;
        chk("R7 restore wrap", 32'(win_ptr), 32'd0);
        rd_chk(5'd16, 32'h1616_0000, "R4 local w0 intact");
        rd_chk(5'd9, 32'hCAFE_0009, "R10 bypass write landed");
        @(negedge clk);

        // R11 pointer load beats save
        ptr_we = 1; ptr_wdata = 5'd5; save_i = 1; step(); idle();
        chk("R11 ptr load", 32'(win_ptr), 32'd5);
        chk("R11 no trap", {30'd0, overflow_trap, underflow_trap}, 32'd0);

        // R12 both strobes
        save_i = 1; restore_i = 1; step(); idle();
        chk("R12 ptr held", 32'(win_ptr), 32'd5);
        chk("R12 no trap", {30'd0, overflow_trap, underflow_trap}, 32'd0);

        // R8 overflow
        mask_we = 1; mask_wdata = 32'h0000_0010; step(); idle();
        chk("R11 mask load", inv_mask, 32'h0000_0010);
        save_i = 1; step(); idle();
        chk("R8 overflow high", 32'(overflow_trap), 32'd1);
        chk("R8 ptr held", 32'(win_ptr), 32'd5);
        step();
        chk("R8 pulse ends", 32'(overflow_trap), 32'd0);

        // R9 underflow
        mask_we = 1; mask_wdata = 32'h0000_0040; step(); idle();
        restore_i = 1; step(); idle();
        chk("R9 underflow high", 32'(underflow_trap), 32'd1);
        chk("R9 ptr held", 32'(win_ptr), 32'd5);
        step();
        chk("R9 pulse ends", 32'(underflow_trap), 32'd0);

        // R5 overlap at window 5 -> 4, R6/R7 plain moves
        wr(5'd9, 32'h5555_0009);
        save_i = 1; step(); idle();
        chk("R6 save 5->4", 32'(win_ptr), 32'd4);
        rd_chk(5'd25, 32'h5555_0009, "R5 out5 seen as in4");
        @(negedge clk);
        restore_i = 1; step(); idle();
        chk("R7 restore 4->5", 32'(win_ptr), 32'd5);
        rd_chk(5'd0, 32'd0, "R2 r0 in w5");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule